// File: doc/BRIEF.md
# Memory Dependence Tracking Unit

This block keeps a small table of the memory operations (loads, stores and memory barriers) that one thread has in flight. Each entry is keyed by its instruction sequence number. The block decides when each operation may issue. A surrounding scheduler drives one command per cycle: insert, registers-ready, non-speculative-ready, completion, reschedule, replay or squash. The block returns the sequence numbers of operations cleared to issue, at most one per cycle.

An entry issues only when two conditions hold. Its source registers must be ready, and the store or barrier it waits on must have completed. The entry it waits on is its producer. For a speculative insert, the producer comes from an outside predictor, which supplies a suggested producer sequence number with each insert. While a barrier is active, the barrier replaces that suggestion. Completing a store or a barrier wakes every entry waiting on it. Rescheduled operations are parked in a replay queue and released together on request. A squash removes every entry and every parked item younger than a bound. Sequence numbers are assumed not to wrap while entries are live.

Top module: `mem_dep_tracker`

## Requirements
- R1: After reset `full` and `rdy_valid` are 0.
- R2: An insert (op 1) of a load (kind 0) or store (kind 1) whose selected producer is 0, or is not a live store or barrier entry, is memory-ready at once. If `cmd_regs_ok` is set, its sequence number is on `rdy_seq` with `rdy_valid` high in the cycle after the insert edge.
- R3: An entry whose producer is a live store waits. Completing that store (op 4) makes the entry ready, and it then appears on the output.
- R4: An entry that is woken while its registers are not ready stays off the output until a registers-ready command (op 2) names it.
- R5: A full barrier (kind 2) makes every later load and store wait on it. Its completion releases them and ends the hold, so later loads issue at once.
- R6: A write barrier (kind 3) makes later stores wait but not loads.
- R7: A barrier's completion ends a hold only if that hold still records the barrier's own sequence number. A younger barrier that replaced it keeps the hold.
- R8: Barriers, and inserts with `cmd_nonspec` set, never issue through the ready flags. Each issues once, on a non-speculative-ready command (op 3). A second such command has no effect.
- R9: A reschedule (op 5) parks a sequence number. A replay (op 6) emits all parked numbers in parking order, one per cycle, ahead of other ready entries.
- R10: A squash (op 7) with bound N removes entries and parked items with sequence number greater than N. Later commands naming them produce no output.
- R11: With all 16 entries live, `full` is 1 and an insert is ignored. A completed entry is freed one cycle after its completion edge.
- R12: Entries that become ready in the same cycle are each emitted exactly once, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 insert, 2 regs-ready, 3 non-spec ready, 4 complete, 5 reschedule, 6 replay, 7 squash |
| cmd_seq | input | SEQ_W | Sequence number named by the command, or squash bound |
| cmd_kind | input | 2 | Insert kind: 0 load, 1 store, 2 full barrier, 3 write barrier |
| cmd_pred | input | SEQ_W | Predicted producer for an insert, 0 for none |
| cmd_nonspec | input | 1 | Insert is non-speculative |
| cmd_regs_ok | input | 1 | Insert already has its registers ready |
| full | output | 1 | No free entry |
| rdy_valid | output | 1 | An operation may issue this cycle |
| rdy_seq | output | SEQ_W | Sequence number of that operation |

## Verification
The bench aims at the barrier bookkeeping. A design that cleared a hold on any barrier completion would let a store slip past a younger write barrier. A design that ignored the hold would issue loads under a full barrier. It checks that a woken entry with unready registers stays quiet: a design that ignored the second flag would issue early. It checks that squashed parked items vanish from a later replay, and that replay keeps its order. It also fills the table to check refusal and the one-cycle delay before a completed entry is freed. Getting either wrong shows as an extra or a missing issue on the output.

// File: rtl/mdt_pkg.sv
// Shared types for the memory dependence tracker.
// Assumes one command per cycle on the command port.
package mdt_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_INSERT   = 3'd1,
        OP_REGS     = 3'd2,
        OP_NSREADY  = 3'd3,
        OP_COMPLETE = 3'd4,
        OP_RESCHED  = 3'd5,
        OP_REPLAY   = 3'd6,
        OP_SQUASH   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        K_LOAD    = 2'd0,
        K_STORE   = 2'd1,
        K_FULLBAR = 2'd2,
        K_WRBAR   = 2'd3
    } kind_e;

    typedef struct packed {
        logic ins;
        logic regs;
        logic nsrdy;
        logic cmpl;
        logic resched;
        logic replay;
        logic squash;
    } cmd_dec_t;

    // One-hot style decode of the command opcode.
    function automatic cmd_dec_t decode(input logic v, input logic [2:0] op);
        cmd_dec_t d;
        d.ins     = v && (op == OP_INSERT);
        d.regs    = v && (op == OP_REGS);
        d.nsrdy   = v && (op == OP_NSREADY);
        d.cmpl    = v && (op == OP_COMPLETE);
        d.resched = v && (op == OP_RESCHED);
        d.replay  = v && (op == OP_REPLAY);
        d.squash  = v && (op == OP_SQUASH);
        return d;
    endfunction

    function automatic logic is_barrier(input kind_e k);
        return (k == K_FULLBAR) || (k == K_WRBAR);
    endfunction

endpackage

// File: rtl/mdt_prod_sel.sv
// Producer selection and barrier hold state.
// Holds a load hold and a store hold, each with the sequence number of the
// barrier that set it. Picks the producer of a speculative insert: the
// matching hold if active, else the predictor suggestion. Non-speculative
// inserts and barriers get producer 0.
// Assumes insert and completion never arrive in the same cycle.
module mdt_prod_sel
    import mdt_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_go,
    input  kind_e            ins_kind,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [SEQ_W-1:0] ins_pred,
    input  logic             ins_nonspec,
    input  logic             cmpl_bar,
    input  logic [SEQ_W-1:0] cmpl_seq,
    output logic [SEQ_W-1:0] prod,
    output logic             nonspec_eff
);

    logic             ld_hold_q;
    logic             st_hold_q;
    logic [SEQ_W-1:0] ld_seq_q;
    logic [SEQ_W-1:0] st_seq_q;

    // Set holds on barrier insert, clear a hold only when its owner completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_hold_q <= 1'b0;
            st_hold_q <= 1'b0;
            ld_seq_q  <= '0;
            st_seq_q  <= '0;
        end else if (ins_go && ins_kind == K_FULLBAR) begin
            ld_hold_q <= 1'b1;
            ld_seq_q  <= ins_seq;
            st_hold_q <= 1'b1;
            st_seq_q  <= ins_seq;
        end else if (ins_go && ins_kind == K_WRBAR) begin
            st_hold_q <= 1'b1;
            st_seq_q  <= ins_seq;
        end else if (cmpl_bar) begin
            if (ld_hold_q && ld_seq_q == cmpl_seq) begin
                ld_hold_q <= 1'b0;
            end
            if (st_hold_q && st_seq_q == cmpl_seq) begin
                st_hold_q <= 1'b0;
            end
        end
    end

    // Choose the producer for the incoming insert.
    always_comb begin
        nonspec_eff = ins_nonspec || is_barrier(ins_kind);
        if (nonspec_eff) begin
            prod = '0;
        end else if (ins_kind == K_LOAD && ld_hold_q) begin
            prod = ld_seq_q;
        end else if (ins_kind == K_STORE && st_hold_q) begin
            prod = st_seq_q;
        end else begin
            prod = ins_pred;
        end
    end

endmodule

// File: rtl/mdt_entry_table.sv
// Entry table of the tracker.
// Each entry keeps its sequence number, kind and producer, plus flags for
// registers-ready, memory-ready, non-speculative, issued (sent), pending
// output and completed (done). A completion of a live store or barrier is
// broadcast to all entries; waiting entries whose producer matches become
// memory-ready. A completed entry is freed on the following edge.
// Assumes sequence numbers are unique among live entries.
module mdt_entry_table
    import mdt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int SEQ_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            do_ins,
    input  logic                            do_regs,
    input  logic                            do_nsrdy,
    input  logic                            do_cmpl,
    input  logic                            do_squash,
    input  logic [SEQ_W-1:0]                cmd_seq,
    input  kind_e                           ins_kind,
    input  logic                            ins_regs_ok,
    input  logic                            ins_nonspec,
    input  logic [SEQ_W-1:0]                prod,
    input  logic [ENTRIES-1:0]              grant,
    output logic                            full,
    output logic                            ins_go,
    output logic                            cmpl_bar,
    output logic [ENTRIES-1:0]              valid_vec,
    output logic [ENTRIES-1:0]              pend_vec,
    output logic [ENTRIES-1:0][SEQ_W-1:0]   seq_arr
);

    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0]            done_q;
    logic [ENTRIES-1:0]            regs_q;
    logic [ENTRIES-1:0]            mem_q;
    logic [ENTRIES-1:0]            ns_q;
    logic [ENTRIES-1:0]            sent_q;
    logic [ENTRIES-1:0]            pend_q;
    logic [ENTRIES-1:0][SEQ_W-1:0] seq_q;
    logic [ENTRIES-1:0][SEQ_W-1:0] prod_q;
    kind_e                         kind_q [ENTRIES];

    logic [ENTRIES-1:0] live;
    logic [ENTRIES-1:0] hit;
    logic [ENTRIES-1:0] prod_hit;
    logic [ENTRIES-1:0] wakeable;
    logic [ENTRIES-1:0] bar_vec;
    logic [IDX_W-1:0]   alloc_idx;
    logic               prod_wait;
    logic               cmpl_wake;

    // Per-entry match vectors against the command and the chosen producer.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            live[i]     = valid_q[i] && !done_q[i];
            hit[i]      = live[i] && (seq_q[i] == cmd_seq);
            wakeable[i] = kind_q[i] != K_LOAD;
            bar_vec[i]  = is_barrier(kind_q[i]);
            prod_hit[i] = live[i] && wakeable[i] && (seq_q[i] == prod);
        end
    end

    // Lowest free slot for allocation.
    always_comb begin
        alloc_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                alloc_idx = IDX_W'(i);
            end
        end
    end

    // Table-level status and completion classification.
    always_comb begin
        full      = &valid_q;
        ins_go    = do_ins && !full;
        prod_wait = !ins_nonspec && (prod != '0) && (|prod_hit);
        cmpl_wake = do_cmpl && |(hit & wakeable);
        cmpl_bar  = do_cmpl && |(hit & bar_vec);
    end

    assign valid_vec = valid_q;
    assign pend_vec  = pend_q;
    assign seq_arr   = seq_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Entry state update: allocate, free, squash, wake, issue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i]  <= 1'b0;
                done_q[i]   <= 1'b0;
                regs_q[i]   <= 1'b0;
                mem_q[i]    <= 1'b0;
                ns_q[i]     <= 1'b0;
                sent_q[i]   <= 1'b0;
                pend_q[i]   <= 1'b0;
                seq_q[i]    <= '0;
                prod_q[i]   <= '0;
                kind_q[i]   <= K_LOAD;
            end else if (ins_go && alloc_idx == IDX_W'(i)) begin
                valid_q[i]  <= 1'b1;
                done_q[i]   <= 1'b0;
                regs_q[i]   <= ins_regs_ok;
                mem_q[i]    <= !prod_wait;
                ns_q[i]     <= ins_nonspec;
                sent_q[i]   <= !ins_nonspec && !prod_wait && ins_regs_ok;
                pend_q[i]   <= !ins_nonspec && !prod_wait && ins_regs_ok;
                seq_q[i]    <= cmd_seq;
                prod_q[i]   <= prod;
                kind_q[i]   <= ins_kind;
            end else if (valid_q[i]) begin
                if (done_q[i] || (do_squash && seq_q[i] > cmd_seq)) begin
                    valid_q[i] <= 1'b0;
                    done_q[i]  <= 1'b0;
                    pend_q[i]  <= 1'b0;
                end else begin
                    if (grant[i]) begin
                        pend_q[i] <= 1'b0;
                    end
                    if (do_regs && hit[i]) begin
                        regs_q[i] <= 1'b1;
                        if (mem_q[i] && !ns_q[i] && !sent_q[i]) begin
                            pend_q[i] <= 1'b1;
                            sent_q[i] <= 1'b1;
                        end
                    end
                    if (do_nsrdy && hit[i] && ns_q[i] && !sent_q[i]) begin
                        pend_q[i] <= 1'b1;
                        sent_q[i] <= 1'b1;
                    end
                    if (do_cmpl && hit[i]) begin
                        done_q[i] <= 1'b1;
                    end
                    if (cmpl_wake && !mem_q[i] && !ns_q[i] && prod_q[i] == cmd_seq) begin
                        mem_q[i] <= 1'b1;
                        if (regs_q[i] && !sent_q[i]) begin
                            pend_q[i] <= 1'b1;
                            sent_q[i] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mdt_replay_q.sv
// Replay queue: a circular buffer of rescheduled sequence numbers.
// A start request snapshots the current occupancy; that many items then
// drain one per cycle from the head. Squashed items stay in place with
// their keep bit cleared and drain silently.
// Assumes DEPTH is a power of two; pushes into a full queue are dropped.
module mdt_replay_q #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic             start,
    input  logic             squash,
    input  logic [SEQ_W-1:0] bound,
    output logic             busy,
    output logic             out_valid,
    output logic [SEQ_W-1:0] out_seq
);

    logic [DEPTH-1:0][SEQ_W-1:0] item_q;
    logic [DEPTH-1:0]            keep_q;
    logic [PTR_W-1:0]            head_q;
    logic [PTR_W-1:0]            tail_q;
    logic [CNT_W-1:0]            count_q;
    logic [CNT_W-1:0]            left_q;
    logic                        push_ok;
    logic                        pop;

    // Drain status and head item.
    always_comb begin
        busy      = left_q != '0;
        pop       = busy;
        push_ok   = push && (count_q != CNT_W'(DEPTH));
        out_valid = busy && keep_q[head_q];
        out_seq   = item_q[head_q];
    end

    // Pointer, occupancy and drain-count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            left_q  <= '0;
        end else begin
            head_q  <= head_q + PTR_W'(pop);
            tail_q  <= tail_q + PTR_W'(push_ok);
            count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop);
            if (start) begin
                left_q <= count_q - CNT_W'(pop);
            end else if (pop) begin
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        // Slot fill, release on pop, and invalidation on squash.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                item_q[k] <= '0;
                keep_q[k] <= 1'b0;
            end else if (push_ok && tail_q == PTR_W'(k)) begin
                item_q[k] <= push_seq;
                keep_q[k] <= 1'b1;
            end else if (pop && head_q == PTR_W'(k)) begin
                keep_q[k] <= 1'b0;
            end else if (squash && item_q[k] > bound) begin
                keep_q[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mdt_ready_arb.sv
// Ready arbiter: grants the lowest-index pending entry when enabled.
// Purely combinational; the grant clears the entry's pending bit.
module mdt_ready_arb #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               enable,
    input  logic [ENTRIES-1:0] pend,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [ENTRIES-1:0] grant
);

    // Lowest-index priority pick.
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
            end
        end
        any   = enable && (|pend);
        grant = any ? (ENTRIES'(1) << idx) : '0;
    end

endmodule

// File: rtl/mem_dep_tracker.sv
// Memory dependence tracker, top level.
// Accepts one command per cycle, tracks loads, stores and barriers of one
// thread, and presents at most one issuable sequence number per cycle.
// Replay drains take priority over ordinary ready entries.
// Assumes sequence numbers are nonzero, unique and do not wrap while live.
module mem_dep_tracker
    import mdt_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int SEQ_W    = 16,
    parameter int RQ_DEPTH = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [SEQ_W-1:0] cmd_seq,
    input  logic [1:0]       cmd_kind,
    input  logic [SEQ_W-1:0] cmd_pred,
    input  logic             cmd_nonspec,
    input  logic             cmd_regs_ok,
    output logic             full,
    output logic             rdy_valid,
    output logic [SEQ_W-1:0] rdy_seq
);

    cmd_dec_t                      dec;
    kind_e                         ins_kind;
    logic [SEQ_W-1:0]              prod;
    logic                          nonspec_eff;
    logic                          ins_go;
    logic                          cmpl_bar;
    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0]            pend_vec;
    logic [ENTRIES-1:0][SEQ_W-1:0] ent_seq;
    logic [ENTRIES-1:0]            grant;
    logic                          arb_any;
    logic [IDX_W-1:0]              arb_idx;
    logic                          rq_busy;
    logic                          rq_valid;
    logic [SEQ_W-1:0]              rq_seq;

    assign dec      = decode(cmd_valid, cmd_op);
    assign ins_kind = kind_e'(cmd_kind);

    mdt_prod_sel #(.SEQ_W(SEQ_W)) u_psel (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_go      (ins_go),
        .ins_kind    (ins_kind),
        .ins_seq     (cmd_seq),
        .ins_pred    (cmd_pred),
        .ins_nonspec (cmd_nonspec),
        .cmpl_bar    (cmpl_bar),
        .cmpl_seq    (cmd_seq),
        .prod        (prod),
        .nonspec_eff (nonspec_eff)
    );

    mdt_entry_table #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) u_tab (
        .clk         (clk),
        .rst_n       (rst_n),
        .do_ins      (dec.ins),
        .do_regs     (dec.regs),
        .do_nsrdy    (dec.nsrdy),
        .do_cmpl     (dec.cmpl),
        .do_squash   (dec.squash),
        .cmd_seq     (cmd_seq),
        .ins_kind    (ins_kind),
        .ins_regs_ok (cmd_regs_ok),
        .ins_nonspec (nonspec_eff),
        .prod        (prod),
        .grant       (grant),
        .full        (full),
        .ins_go      (ins_go),
        .cmpl_bar    (cmpl_bar),
        .valid_vec   (ent_valid),
        .pend_vec    (pend_vec),
        .seq_arr     (ent_seq)
    );

    mdt_replay_q #(.DEPTH(RQ_DEPTH), .SEQ_W(SEQ_W)) u_rq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (dec.resched),
        .push_seq  (cmd_seq),
        .start     (dec.replay),
        .squash    (dec.squash),
        .bound     (cmd_seq),
        .busy      (rq_busy),
        .out_valid (rq_valid),
        .out_seq   (rq_seq)
    );

    mdt_ready_arb #(.ENTRIES(ENTRIES)) u_arb (
        .enable (!rq_busy),
        .pend   (pend_vec),
        .any    (arb_any),
        .idx    (arb_idx),
        .grant  (grant)
    );

    // Output select: replay drain first, then the arbitrated entry.
    always_comb begin
        rdy_valid = rq_valid || arb_any;
        rdy_seq   = rq_valid ? rq_seq : ent_seq[arb_idx];
    end

endmodule

// File: rtl/mdt_checker.sv
// Property checker for the memory dependence tracker, bound to the top.
module mdt_checker
    import mdt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int SEQ_W   = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cmd_valid,
    input logic [2:0]                    cmd_op,
    input logic [SEQ_W-1:0]              cmd_seq,
    input logic                          full,
    input logic                          rdy_valid,
    input logic [ENTRIES-1:0]            ent_valid,
    input logic [ENTRIES-1:0][SEQ_W-1:0] ent_seq,
    input logic                          rq_busy,
    input logic                          rq_valid
);

    logic             sq_d;
    logic [SEQ_W-1:0] bound_d;
    logic             young_live;

    // Remember the last squash and its bound.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_d    <= 1'b0;
            bound_d <= '0;
        end else begin
            sq_d    <= cmd_valid && cmd_op == OP_SQUASH;
            bound_d <= cmd_seq;
        end
    end

    // Any live entry younger than the remembered bound.
    always_comb begin
        young_live = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_valid[i] && ent_seq[i] > bound_d) begin
                young_live = 1'b1;
            end
        end
    end

    assert_refuse_when_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_INSERT && full)
        |=> ($countones(ent_valid) <= $past($countones(ent_valid))));

    assert_full_rises_on_insert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(cmd_valid && cmd_op == OP_INSERT));

    assert_empty_not_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid == '0) |-> !full);

    assert_replay_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_busy && !rq_valid) |-> !rdy_valid);

    assert_squash_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sq_d |-> !young_live);

endmodule

bind mem_dep_tracker mdt_checker #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_seq   (cmd_seq),
    .full      (full),
    .rdy_valid (rdy_valid),
    .ent_valid (ent_valid),
    .ent_seq   (ent_seq),
    .rq_busy   (rq_busy),
    .rq_valid  (rq_valid)
);

// File: tb/tb_mem_dep_tracker.sv
`timescale 1ns/1ps
module tb_mem_dep_tracker;

    localparam int SEQ_W = 16;
    localparam int OPI = 1, OPR = 2, OPN = 3, OPC = 4, OPS = 5, OPP = 6, OPQ = 7;
    localparam int KL = 0, KS = 1, KF = 2, KW = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [SEQ_W-1:0] cmd_seq = '0;
    logic [1:0]       cmd_kind = '0;
    logic [SEQ_W-1:0] cmd_pred = '0;
    logic             cmd_nonspec = 1'b0;
    logic             cmd_regs_ok = 1'b0;
    logic             full;
    logic             rdy_valid;
    logic [SEQ_W-1:0] rdy_seq;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int log_seq [64];
    int log_n = 0;

    always #10 clk = ~clk;

    mem_dep_tracker dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_seq(cmd_seq), .cmd_kind(cmd_kind), .cmd_pred(cmd_pred),
        .cmd_nonspec(cmd_nonspec), .cmd_regs_ok(cmd_regs_ok),
        .full(full), .rdy_valid(rdy_valid), .rdy_seq(rdy_seq)
    );

    // Record every issued sequence number, once per cycle.
    always @(negedge clk) begin
        if (rst_n && rdy_valid) begin
            if (log_n < 64) log_seq[log_n] = int'(rdy_seq);
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmd(input int op, input int seq, input int kind, input int pred,
                       input bit ns, input bit rok);
        cmd_valid   = 1'b1;
        cmd_op      = 3'(op);
        cmd_seq     = SEQ_W'(seq);
        cmd_kind    = 2'(kind);
        cmd_pred    = SEQ_W'(pred);
        cmd_nonspec = ns;
        cmd_regs_ok = rok;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fresh();
        cmd(OPQ, 0, 0, 0, 0, 0);
        idle(4);
        log_n = 0;
    endtask

    task automatic expect_log(input string req, input int n,
                              input int e0, input int e1, input int e2);
        int exp [3];
        exp[0] = e0; exp[1] = e1; exp[2] = e2;
        idle(4);
        check(log_n == n, req, "issue count", log_n, n);
        for (int i = 0; i < n && i < 3 && i < log_n; i++)
            check(log_seq[i] == exp[i], req, "issue order", log_seq[i], exp[i]);
    endtask

    task automatic t_reset();
        check(full == 1'b0, "R1", "full after reset", int'(full), 0);
        check(rdy_valid == 1'b0, "R1", "rdy_valid after reset", int'(rdy_valid), 0);
    endtask

    task automatic t_immediate();
        fresh();
        cmd(OPI, 10, KL, 0, 0, 1);
        check(rdy_valid && rdy_seq == 10, "R2", "seq right after insert", int'(rdy_seq), 10);
        cmd(OPI, 11, KS, 99, 0, 1);
        expect_log("R2", 2, 10, 11, 0);
    endtask

    task automatic t_store_wake();
        fresh();
        cmd(OPI, 20, KS, 0, 0, 1);
        cmd(OPI, 21, KL, 20, 0, 1);
        expect_log("R3", 1, 20, 0, 0);
        cmd(OPC, 20, 0, 0, 0, 0);
        expect_log("R3", 2, 20, 21, 0);
        cmd(OPC, 21, 0, 0, 0, 0);
    endtask

    task automatic t_two_flags();
        fresh();
        cmd(OPI, 30, KS, 0, 0, 1);
        cmd(OPI, 31, KL, 30, 0, 0);
        cmd(OPC, 30, 0, 0, 0, 0);
        expect_log("R4", 1, 30, 0, 0);
        cmd(OPR, 31, 0, 0, 0, 0);
        expect_log("R4", 2, 30, 31, 0);
    endtask

    task automatic t_full_barrier();
        fresh();
        cmd(OPI, 40, KF, 0, 0, 1);
        expect_log("R8", 0, 0, 0, 0);
        cmd(OPN, 40, 0, 0, 0, 0);
        cmd(OPI, 41, KL, 0, 0, 1);
        cmd(OPI, 42, KS, 0, 0, 1);
        expect_log("R5", 1, 40, 0, 0);
        cmd(OPC, 40, 0, 0, 0, 0);
        expect_log("R12", 3, 40, 41, 42);
        cmd(OPI, 43, KL, 0, 0, 1);
        expect_log("R5", 4, 40, 41, 42);
        check(log_seq[3] == 43, "R5", "load after release", log_seq[3], 43);
    endtask

    task automatic t_write_barrier();
        fresh();
        cmd(OPI, 50, KW, 0, 0, 0);
        cmd(OPI, 51, KL, 0, 0, 1);
        cmd(OPI, 52, KS, 0, 0, 1);
        expect_log("R6", 1, 51, 0, 0);
        cmd(OPC, 50, 0, 0, 0, 0);
        expect_log("R6", 2, 51, 52, 0);
    endtask

    task automatic t_replaced_barrier();
        fresh();
        cmd(OPI, 60, KF, 0, 0, 0);
        cmd(OPI, 61, KW, 0, 0, 0);
        cmd(OPC, 60, 0, 0, 0, 0);
        cmd(OPI, 62, KL, 0, 0, 1);
        cmd(OPI, 63, KS, 0, 0, 1);
        expect_log("R7", 1, 62, 0, 0);
        cmd(OPC, 61, 0, 0, 0, 0);
        expect_log("R7", 2, 62, 63, 0);
    endtask

    task automatic t_nonspec();
        fresh();
        cmd(OPI, 70, KL, 0, 1, 1);
        cmd(OPR, 70, 0, 0, 0, 0);
        expect_log("R8", 0, 0, 0, 0);
        cmd(OPN, 70, 0, 0, 0, 0);
        cmd(OPN, 70, 0, 0, 0, 0);
        expect_log("R8", 1, 70, 0, 0);
    endtask

    task automatic t_replay();
        fresh();
        cmd(OPI, 80, KL, 0, 0, 0);
        cmd(OPI, 81, KL, 0, 0, 0);
        cmd(OPI, 82, KL, 0, 0, 0);
        cmd(OPS, 80, 0, 0, 0, 0);
        cmd(OPS, 81, 0, 0, 0, 0);
        cmd(OPS, 82, 0, 0, 0, 0);
        expect_log("R9", 0, 0, 0, 0);
        cmd(OPP, 81, 0, 0, 0, 0);
        expect_log("R9", 3, 80, 81, 82);
    endtask

    task automatic t_squash();
        fresh();
        cmd(OPI, 90, KL, 0, 0, 0);
        cmd(OPI, 91, KL, 0, 0, 0);
        cmd(OPI, 92, KL, 0, 0, 0);
        cmd(OPS, 91, 0, 0, 0, 0);
        cmd(OPS, 92, 0, 0, 0, 0);
        cmd(OPQ, 90, 0, 0, 0, 0);
        cmd(OPR, 91, 0, 0, 0, 0);
        cmd(OPP, 91, 0, 0, 0, 0);
        expect_log("R10", 0, 0, 0, 0);
        cmd(OPR, 90, 0, 0, 0, 0);
        expect_log("R10", 1, 90, 0, 0);
    endtask

    task automatic t_full();
        fresh();
        for (int i = 0; i < 16; i++) cmd(OPI, 100 + i, KL, 0, 0, 0);
        check(full == 1'b1, "R11", "full with 16 live", int'(full), 1);
        cmd(OPI, 116, KL, 0, 0, 1);
        cmd(OPR, 116, 0, 0, 0, 0);
        expect_log("R11", 0, 0, 0, 0);
        cmd(OPC, 100, 0, 0, 0, 0);
        check(full == 1'b1, "R11", "full on completion edge", int'(full), 1);
        idle(1);
        check(full == 1'b0, "R11", "full one cycle later", int'(full), 0);
        cmd(OPI, 117, KL, 0, 0, 1);
        expect_log("R11", 1, 117, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_immediate();
        t_store_wake();
        t_two_flags();
        t_full_barrier();
        t_write_barrier();
        t_replaced_barrier();
        t_nonspec();
        t_replay();
        t_squash();
        t_full();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule